// File: doc/BRIEF.md
# Read-Sequence Unlocked Recall Controller

This controller stands between a host port and a byte-wide SRAM array whose contents are backed by a shadow nonvolatile array. In normal operation it passes host read and write cycles straight through to the SRAM. It also watches every chip-enable read cycle for a hidden unlock pattern of six read addresses. There is no command register or control pin for this purpose. When the sixth matching read completes, the controller takes over the array ports and performs a recall.

A recall runs in two passes. The first pass writes zero to every SRAM location in ascending order. The second pass copies each shadow location into the same SRAM address, one location per clock. The controller then stays busy until a fixed, parameterised number of cycles has passed. During that whole window host accesses are ignored. The shadow array has no write path from this block, so a recall can be repeated any number of times with the same result.

Top module: `nvr_recall_ctrl`

## Requirements
- R1: A chip-enable read cycle (`ce_n`=0, `we_n`=1) is one step of the unlock pattern. Six such steps at addresses 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F and 0x0C63, taken in that order, raise `busy` at the clock edge that ends the sixth read.
- R2: Every read cycle outside a recall returns the SRAM data at `addr` on `rd_data` in the same cycle, including the six reads of the pattern.
- R3: A read whose address is not the next expected step drops the matcher back to idle. If that read is at 0x0E38, the matcher instead resumes at the second step.
- R4: Any write cycle (`ce_n`=0, `we_n`=0) returns the matcher to idle.
- R5: Cycles with `ce_n`=1 leave the matcher state untouched, so idle gaps between pattern steps are allowed.
- R6: In busy cycles 0 to DEPTH-1 the controller writes zero to SRAM address k in busy cycle k.
- R7: In busy cycles DEPTH to 2*DEPTH-1 the controller writes the shadow byte at address k into SRAM address k in busy cycle DEPTH+k.
- R8: `busy` stays high for exactly RECALL_CYCLES cycles, and no SRAM write occurs after the copy pass. Once `busy` drops, normal reads and writes resume.
- R9: While `busy` is high, `rd_data` is zero, host writes do not reach the SRAM, and host reads do not advance the matcher.
- R10: The shadow array is read only, so a second recall leaves the SRAM identical to the shadow contents, whatever the host wrote in between.
- R11: Outside a recall, a write cycle stores `host_wdata` at `addr`. A read cycle with `oe_n`=1 returns zero on `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Host chip enable, active low |
| oe_n | input | 1 | Host output enable, active low |
| we_n | input | 1 | Host write enable, active low |
| addr | input | AW | Host address |
| host_wdata | input | DW | Host write data |
| rd_data | output | DW | Host read data, zero when not driven |
| busy | output | 1 | Recall in progress |
| sram_addr | output | AW | SRAM address |
| sram_we | output | 1 | SRAM write strobe, applied at the clock edge |
| sram_wdata | output | DW | SRAM write data |
| sram_rdata | input | DW | SRAM asynchronous read data |
| nv_addr | output | AW | Shadow array read address |
| nv_rdata | input | DW | Shadow array asynchronous read data |

## Verification
Read data is combinational. It is sampled a few ns after the inputs change at the falling edge, and before the rising edge that closes the cycle. `busy` is registered, so it is expected at the falling edge that follows the edge ending the sixth read. From that falling edge, busy cycle k is counted and the clear and copy strobes for address k are checked in that same half-cycle. SRAM writes take effect at the rising edge. The bench therefore compares its own array model only after the recall has ended, against shadow bytes it computes itself.

// File: rtl/nvr_pkg.sv
package nvr_pkg;

   localparam int SEQ_LEN = 6;
   localparam int SEQ_AW  = 15;

   // unlock pattern, order is behaviour
   function automatic logic [SEQ_AW-1:0] seq_at(input int k);
      logic [SEQ_AW-1:0] v;
      case (k)
         0:       v = 15'h0E38;
         1:       v = 15'h31C7;
         2:       v = 15'h03E0;
         3:       v = 15'h3C1F;
         4:       v = 15'h303F;
         default: v = 15'h0C63;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/nvr_seq_match.sv
module nvr_seq_match
   import nvr_pkg::*;
#(
   parameter int AW = 15
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_cyc,
   input  logic          wr_cyc,
   input  logic          hold,
   input  logic [AW-1:0] addr,
   output logic          fire
);

   localparam int SW = 3;
   localparam logic [SW-1:0] LAST = SW'(SEQ_LEN - 1);

   logic [7:0]    hit;
   logic [SW-1:0] step;

   for (genvar k = 0; k < 8; k++) begin : g_cmp
      if (k < SEQ_LEN) begin : g_live
         localparam logic [SEQ_AW-1:0] V = seq_at(k);
         assign hit[k] = (addr == AW'(V));
      end else begin : g_pad
         assign hit[k] = 1'b0;
      end
   end

   assign fire = rd_cyc && !hold && hit[step] && (step == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step <= '0;
      end else if (!hold) begin
         if (wr_cyc) begin
            step <= '0;
         end else if (rd_cyc) begin
            if (hit[step])
               step <= (step == LAST) ? '0 : step + 1'b1;
            else if (hit[0])
               step <= SW'(1);
            else
               step <= '0;
         end
      end
   end

endmodule

// File: rtl/nvr_recall_engine.sv
module nvr_recall_engine #(
   parameter int AW = 15,
   parameter int RC = 65552
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          busy,
   output logic [AW-1:0] eng_addr,
   output logic          eng_we,
   output logic          eng_copy
);

   localparam longint DEPTH = longint'(1) << AW;
   localparam int     TW    = $clog2(RC) + 1;
   localparam logic [TW-1:0] T_LAST  = TW'(RC - 1);
   localparam logic [TW-1:0] T_CLEAR = TW'(DEPTH);
   localparam logic [TW-1:0] T_COPY  = TW'(2 * DEPTH);

   logic [TW-1:0] tmr;
   logic          in_clear;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         tmr  <= '0;
      end else if (!busy) begin
         busy <= start;
         tmr  <= '0;
      end else begin
         if (tmr == T_LAST)
            busy <= 1'b0;
         tmr <= tmr + 1'b1;
      end
   end

   assign eng_addr = tmr[AW-1:0];
   assign in_clear = busy && (tmr < T_CLEAR);
   assign eng_copy = busy && !in_clear && (tmr < T_COPY);
   assign eng_we   = in_clear || eng_copy;

endmodule

// File: rtl/nvr_recall_ctrl.sv
module nvr_recall_ctrl #(
   parameter int AW = 15,
   parameter int DW = 8,
   parameter int RECALL_CYCLES = 2 * (1 << 15) + 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ce_n,
   input  logic          oe_n,
   input  logic          we_n,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] host_wdata,
   output logic [DW-1:0] rd_data,
   output logic          busy,
   output logic [AW-1:0] sram_addr,
   output logic          sram_we,
   output logic [DW-1:0] sram_wdata,
   input  logic [DW-1:0] sram_rdata,
   output logic [AW-1:0] nv_addr,
   input  logic [DW-1:0] nv_rdata
);

   if (AW < 14 || AW > 24) begin : g_bad_aw
      $error("nvr_recall_ctrl: AW must be 14..24 to hold the unlock addresses");
   end
   if (DW < 1) begin : g_bad_dw
      $error("nvr_recall_ctrl: DW must be positive");
   end
   if (longint'(RECALL_CYCLES) < 2 * (longint'(1) << AW)) begin : g_bad_rc
      $error("nvr_recall_ctrl: RECALL_CYCLES must cover clear and copy passes");
   end

   logic          rd_cyc;
   logic          wr_cyc;
   logic          fire;
   logic [AW-1:0] eng_addr;
   logic          eng_we;
   logic          eng_copy;

   assign rd_cyc = !ce_n && we_n;
   assign wr_cyc = !ce_n && !we_n;

   nvr_seq_match #(.AW(AW)) u_match (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_cyc (rd_cyc),
      .wr_cyc (wr_cyc),
      .hold   (busy),
      .addr   (addr),
      .fire   (fire)
   );

   nvr_recall_engine #(.AW(AW), .RC(RECALL_CYCLES)) u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (fire),
      .busy     (busy),
      .eng_addr (eng_addr),
      .eng_we   (eng_we),
      .eng_copy (eng_copy)
   );

   always_comb begin
      if (busy) begin
         sram_addr  = eng_addr;
         sram_we    = eng_we;
         sram_wdata = eng_copy ? nv_rdata : '0;
      end else begin
         sram_addr  = addr;
         sram_we    = wr_cyc;
         sram_wdata = host_wdata;
      end
   end

   assign nv_addr = eng_addr;
   assign rd_data = (!busy && rd_cyc && !oe_n) ? sram_rdata : '0;

endmodule

// File: rtl/nvr_recall_chk.sv
module nvr_recall_chk #(
   parameter int AW = 15,
   parameter int DW = 8,
   parameter int RC = 65552
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ce_n,
   input logic          we_n,
   input logic [AW-1:0] addr,
   input logic [DW-1:0] host_wdata,
   input logic [DW-1:0] rd_data,
   input logic          busy,
   input logic [AW-1:0] sram_addr,
   input logic          sram_we,
   input logic [DW-1:0] sram_wdata,
   input logic [AW-1:0] nv_addr,
   input logic [DW-1:0] nv_rdata
);

   localparam longint DEPTH = longint'(1) << AW;
   localparam int     TW    = $clog2(RC) + 1;
   localparam logic [AW-1:0] LAST_ADDR = AW'(15'h0C63);

   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (busy) cnt <= cnt + 1'b1;
      else           cnt <= '0;
   end

   p_trigger_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(!ce_n && we_n && addr == LAST_ADDR));

   p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cnt < TW'(DEPTH)) |->
         (sram_we && sram_wdata == '0 && sram_addr == cnt[AW-1:0]));

   p_copy_shadow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cnt >= TW'(DEPTH) && cnt < TW'(2 * DEPTH)) |->
         (sram_we && sram_wdata == nv_rdata && sram_addr == nv_addr
          && sram_addr == cnt[AW-1:0]));

   p_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($past(cnt) == TW'(RC - 1)));

   p_hold_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cnt >= TW'(2 * DEPTH)) |-> !sram_we);

   p_no_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (rd_data == '0));

   p_host_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && sram_we) |->
         (!ce_n && !we_n && sram_addr == addr && sram_wdata == host_wdata));

endmodule

bind nvr_recall_ctrl nvr_recall_chk #(.AW(AW), .DW(DW), .RC(RECALL_CYCLES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ce_n       (ce_n),
   .we_n       (we_n),
   .addr       (addr),
   .host_wdata (host_wdata),
   .rd_data    (rd_data),
   .busy       (busy),
   .sram_addr  (sram_addr),
   .sram_we    (sram_we),
   .sram_wdata (sram_wdata),
   .nv_addr    (nv_addr),
   .nv_rdata   (nv_rdata)
);

// File: tb/sim_nvr_recall_ctrl.sv
`timescale 1ns/1ps
module sim_nvr_recall_ctrl;

   localparam int AW    = 14;
   localparam int DW    = 8;
   localparam int DEPTH = 1 << AW;
   localparam int RC    = 2 * DEPTH + 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] host_wdata = '0;
   logic [DW-1:0] rd_data, sram_wdata, sram_rdata, nv_rdata;
   logic [AW-1:0] sram_addr, nv_addr;
   logic          busy, sram_we;

   logic [DW-1:0] mem [DEPTH];
   int checks = 0;
   int errors = 0;
   logic [AW-1:0] useq [6];

   always #5 clk = ~clk;

   function automatic logic [DW-1:0] nvf(input int k);
      return DW'((k * 37) ^ (k >> 6) ^ 8'h5C);
   endfunction

   assign nv_rdata   = nvf(int'(nv_addr));
   assign sram_rdata = mem[sram_addr];
   always @(posedge clk) if (sram_we) mem[sram_addr] <= sram_wdata;

   nvr_recall_ctrl #(.AW(AW), .DW(DW), .RECALL_CYCLES(RC)) u0 (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .host_wdata(host_wdata), .rd_data(rd_data), .busy(busy),
      .sram_addr(sram_addr), .sram_we(sram_we), .sram_wdata(sram_wdata),
      .sram_rdata(sram_rdata), .nv_addr(nv_addr), .nv_rdata(nv_rdata)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_read(input logic [AW-1:0] a, input logic oe, output logic [DW-1:0] d);
      @(negedge clk);
      ce_n = 1'b0; we_n = 1'b1; oe_n = oe; addr = a;
      #2 d = rd_data;
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] v);
      @(negedge clk);
      ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; host_wdata = v;
   endtask

   task automatic do_idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
      end
   endtask

   // runs a recall from its first busy cycle; optional host stimulus while busy
   task automatic run_recall(input bit poke);
      int n = 0, e_clr = 0, e_cpy = 0, e_hold = 0, e_rd = 0;
      @(negedge clk);
      chk(busy === 1'b1, "R1 busy after sixth read", int'(busy), 1);
      while (busy === 1'b1 && n < RC + 10) begin
         if (n < DEPTH) begin
            if (!(sram_we && sram_wdata == 0 && sram_addr == AW'(n))) e_clr++;
         end else if (n < 2 * DEPTH) begin
            if (!(sram_we && sram_addr == AW'(n - DEPTH) && sram_wdata == nvf(n - DEPTH))) e_cpy++;
         end else if (sram_we) e_hold++;
         if (poke && n == 3) begin
            ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = AW'(100); host_wdata = 8'h5A;
         end else begin
            ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0;
            addr = (poke && n >= 10 && n < 16) ? useq[n-10] : AW'(n);
            #1 if (rd_data !== '0) e_rd++;
         end
         @(negedge clk);
         n++;
      end
      ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
      chk(e_clr == 0, "R6 clear pass", e_clr, 0);
      chk(e_cpy == 0, "R7 copy pass", e_cpy, 0);
      chk(e_hold == 0, "R8 no write after copy", e_hold, 0);
      chk(n == RC, "R8 busy length", n, RC);
      chk(e_rd == 0, "R9 read data zero while busy", e_rd, 0);
   endtask

   task automatic cmp_shadow(input string req);
      int bad = 0;
      for (int k = 0; k < DEPTH; k++) if (mem[k] !== nvf(k)) bad++;
      chk(bad == 0, req, bad, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [DW-1:0] d;
      int bad;
      useq[0] = AW'(15'h0E38); useq[1] = AW'(15'h31C7); useq[2] = AW'(15'h03E0);
      useq[3] = AW'(15'h3C1F); useq[4] = AW'(15'h303F); useq[5] = AW'(15'h0C63);
      for (int k = 0; k < DEPTH; k++) mem[k] = '0;
      repeat (3) @(negedge clk);
      chk(busy === 1'b0 && rd_data === '0, "reset state", int'(busy), 0);
      rst_n = 1'b1;

      // R11 host writes, then R2 reads back
      for (int k = 0; k < 6; k++) do_write(useq[k], DW'(8'hA0 + k));
      do_write(AW'(100), 8'h33);
      do_idle(1);
      do_read(AW'(100), 1'b0, d);
      chk(d == 8'h33, "R11 write then read", d, 8'h33);
      do_read(AW'(100), 1'b1, d);
      chk(d == 8'h00, "R11 oe_n high gives zero", d, 0);

      // R3 wrong address in middle
      for (int k = 0; k < 4; k++) do_read(useq[k], 1'b0, d);
      do_read(AW'(1), 1'b0, d);
      do_read(useq[4], 1'b0, d);
      do_read(useq[5], 1'b0, d);
      do_idle(2);
      chk(busy === 1'b0, "R3 mismatch aborts", int'(busy), 0);

      // R4 write in middle
      for (int k = 0; k < 3; k++) do_read(useq[k], 1'b0, d);
      do_write(AW'(200), 8'h11);
      for (int k = 3; k < 6; k++) do_read(useq[k], 1'b0, d);
      do_idle(2);
      chk(busy === 1'b0, "R4 write aborts", int'(busy), 0);

      // R3 restart at step two, R5 idle gaps, R2 data during pattern
      do_read(useq[0], 1'b0, d);
      do_read(useq[1], 1'b0, d);
      bad = 0;
      for (int k = 0; k < 6; k++) begin
         do_read(useq[k], 1'b0, d);
         if (d !== DW'(8'hA0 + k)) bad++;
         if (k < 5) begin
            do_idle(2);
            if (busy !== 1'b0) bad++;
         end
      end
      chk(bad == 0, "R2 pattern reads return data", bad, 0);
      run_recall(1'b1);   // R3 R5 trigger checked inside

      do_idle(3);
      chk(busy === 1'b0, "R9 reads during busy ignored by matcher", int'(busy), 0);
      cmp_shadow("R7 sram equals shadow");
      chk(mem[100] == nvf(100), "R9 host write while busy dropped", mem[100], nvf(100));

      // R8 normal access resumes
      do_write(AW'(5), 8'hC3);
      do_read(AW'(5), 1'b0, d);
      chk(d == 8'hC3, "R8 access after recall", d, 8'hC3);

      // R10 second recall restores shadow image
      for (int k = 0; k < 8; k++) do_write(AW'(k), 8'hEE);
      bad = 0;
      for (int k = 0; k < 6; k++) begin
         do_read(useq[k], 1'b0, d);
         if (d !== nvf(int'(useq[k]))) bad++;
      end
      chk(bad == 0, "R2 reads after recall", bad, 0);
      run_recall(1'b0);
      do_idle(1);
      cmp_shadow("R10 repeated recall identical");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule